// File: doc/BRIEF.md
# Multi-Format Serial Line Encoder

This block turns parallel transmit bytes into one serial line signal. The line code is chosen per frame: plain level coding (NRZ), transition-on-zero coding (NRZI) or bi-phase coding (Manchester). An external rate generator supplies two single-cycle strobes. `cell_stb` marks the start of each bit cell. `mid_stb` marks the middle of each bit cell. All line changes are registered on the system clock in the cycle after one of these strobes.

Bytes come in over a valid/ready handshake into a one-entry holding register. A frame opens on the first cell strobe that finds a byte waiting. The block can first send a programmable synchronisation preamble of 0 to 15 bit cells. It then shifts data out least significant bit first and chains further bytes without a gap, as long as each one is waiting at the byte boundary. The frame closes on the first cell strobe that finds the shifter empty and no byte held. The line then rests at the marking (high) level.

Top module: `mfmt_line_enc`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_out` is 1. After reset `tx_ready` is 1. A reset during a frame abandons it and returns `line_out` to 1 and `tx_ready` to 1.
- R2: A byte is taken when `tx_valid` and `tx_ready` are both 1 at a clock edge. `tx_ready` is then 0 until a cell strobe moves the held byte into the shifter.
- R3: With format code 00 (NRZ), the line takes the bit value in the cycle after the cell strobe and keeps it through the mid strobe.
- R4: With format code 01 (NRZI), a 0 bit inverts the line at the start of the cell and a 1 bit keeps it. The line level is taken as 1 just before the first cell of each frame, and it carries across byte boundaries within the frame.
- R5: With format code 10 (Manchester), the line equals the bit value in the first half of the cell. After the mid strobe it equals the inverse, so a 1 goes high-to-low and a 0 goes low-to-high in mid-cell.
- R6: Data leaves least significant bit first. A byte held at the cell strobe that ends the previous byte follows it in the very next cell, with no idle cell between.
- R7: `pre_len` sets a preamble of that many cells (0 to 15) before the first data bit. For NRZ and NRZI the preamble bits are 0. For Manchester they alternate, starting with 1.
- R8: Format code 11 behaves as NRZ. Format and preamble length are sampled at the cell strobe that opens a frame; changes to them during the frame have no effect until the next frame.
- R9: On the cell strobe after the last data bit, with no byte held, the line returns to 1 in the next cycle and stays there.
- R10: `line_out` changes only in the cycle right after a cell strobe or a mid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_stb | input | 1 | One-cycle pulse at the start of each bit cell |
| mid_stb | input | 1 | One-cycle pulse in the middle of each bit cell |
| fmt_sel | input | 2 | Line code: 00 NRZ, 01 NRZI, 10 Manchester, 11 NRZ |
| pre_len | input | PRE_W | Preamble length in bit cells |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register is free |
| line_out | output | 1 | Encoded serial line |

## Verification
Two events can fall in one clock cycle: the handshake that refills the holding register, and a cell strobe that makes the sequencer emit a bit. The bench offers each follow-on byte in the very cycle of a cell strobe, right after the previous byte has moved to the shifter. The refill must then neither disturb the bit sent in that cell nor be lost. This is judged by comparing every half-cell of the line with a waveform the bench computes from the bit stream. That comparison also shows the NRZI level carrying across the byte boundary with no gap.

// File: rtl/lxe_pkg.sv
package lxe_pkg;

   typedef enum logic [1:0] {
      FMT_NRZ   = 2'b00,
      FMT_NRZI  = 2'b01,
      FMT_MANCH = 2'b10,
      FMT_RSVD  = 2'b11
   } lxe_fmt_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'b00,
      SQ_PRE  = 2'b01,
      SQ_DATA = 2'b10
   } lxe_sq_e;

   // reserved code falls back to level coding
   function automatic lxe_fmt_e lxe_norm(input logic [1:0] code);
      lxe_fmt_e f;
      if (code == 2'b11) f = FMT_NRZ;
      else               f = lxe_fmt_e'(code);
      return f;
   endfunction

   // preamble bit for a given cell parity: zeros, or 1/0 alternation for bi-phase
   function automatic logic lxe_pre_bit(input lxe_fmt_e f, input logic odd_cell);
      logic b;
      if (f == FMT_MANCH) b = ~odd_cell;
      else                b = 1'b0;
      return b;
   endfunction

endpackage

// File: rtl/lxe_hold.sv
module lxe_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (in_valid && !full) begin
         full <= 1'b1;
         data <= in_data;
      end else if (take) begin
         full <= 1'b0;
      end
   end

   assign in_ready = !full;

endmodule

// File: rtl/lxe_seq.sv
module lxe_seq
   import lxe_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PRE_W     = 4,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cell_stb,
   input  logic [1:0]        fmt_in,
   input  logic [PRE_W-1:0]  pre_len_in,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   output logic              take,
   output logic              emit,
   output logic              emit_bit,
   output logic              start,
   output logic              to_idle,
   output lxe_fmt_e          fmt_cur,
   output logic              active
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam int PCW   = PRE_W + 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   lxe_sq_e            st_q, st_d;
   logic [PRE_W-1:0]   pidx_q, pidx_d;
   logic [PRE_W-1:0]   plen_q, plen_d;
   lxe_fmt_e           fmt_q, fmt_d, fmt_new;
   logic [DATA_W-1:0]  sh_q, sh_d;
   logic [CNT_W-1:0]   left_q, left_d;

   logic               hold_head, sh_head;
   logic [DATA_W-1:0]  hold_rest, sh_rest;
   logic               pre_more;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign hold_head = hold_data[0];
         assign hold_rest = {1'b0, hold_data[DATA_W-1:1]};
         assign sh_head   = sh_q[0];
         assign sh_rest   = {1'b0, sh_q[DATA_W-1:1]};
      end else begin : g_msb
         assign hold_head = hold_data[DATA_W-1];
         assign hold_rest = {hold_data[DATA_W-2:0], 1'b0};
         assign sh_head   = sh_q[DATA_W-1];
         assign sh_rest   = {sh_q[DATA_W-2:0], 1'b0};
      end
   endgenerate

   assign fmt_new  = lxe_norm(fmt_in);
   assign pre_more = ({1'b0, pidx_q} + PCW'(1)) < {1'b0, plen_q};

   always_comb begin
      take     = 1'b0;
      emit     = 1'b0;
      emit_bit = 1'b0;
      start    = 1'b0;
      to_idle  = 1'b0;
      st_d     = st_q;
      pidx_d   = pidx_q;
      plen_d   = plen_q;
      fmt_d    = fmt_q;
      sh_d     = sh_q;
      left_d   = left_q;
      if (cell_stb) begin
         unique case (st_q)
            SQ_IDLE: begin
               if (hold_full) begin
                  start  = 1'b1;
                  emit   = 1'b1;
                  fmt_d  = fmt_new;
                  plen_d = pre_len_in;
                  if (pre_len_in != '0) begin
                     st_d     = SQ_PRE;
                     pidx_d   = '0;
                     emit_bit = lxe_pre_bit(fmt_new, 1'b0);
                  end else begin
                     take     = 1'b1;
                     st_d     = SQ_DATA;
                     emit_bit = hold_head;
                     sh_d     = hold_rest;
                     left_d   = LAST;
                  end
               end
            end
            SQ_PRE: begin
               emit = 1'b1;
               if (pre_more) begin
                  pidx_d   = pidx_q + PRE_W'(1);
                  emit_bit = lxe_pre_bit(fmt_q, ~pidx_q[0]);
               end else begin
                  take     = 1'b1;
                  st_d     = SQ_DATA;
                  emit_bit = hold_head;
                  sh_d     = hold_rest;
                  left_d   = LAST;
               end
            end
            SQ_DATA: begin
               if (left_q != '0) begin
                  emit     = 1'b1;
                  emit_bit = sh_head;
                  sh_d     = sh_rest;
                  left_d   = left_q - CNT_W'(1);
               end else if (hold_full) begin
                  emit     = 1'b1;
                  take     = 1'b1;
                  emit_bit = hold_head;
                  sh_d     = hold_rest;
                  left_d   = LAST;
               end else begin
                  to_idle = 1'b1;
                  st_d    = SQ_IDLE;
               end
            end
            default: st_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         pidx_q <= '0;
         plen_q <= '0;
         fmt_q  <= FMT_NRZ;
         sh_q   <= '0;
         left_q <= '0;
      end else begin
         st_q   <= st_d;
         pidx_q <= pidx_d;
         plen_q <= plen_d;
         fmt_q  <= fmt_d;
         sh_q   <= sh_d;
         left_q <= left_d;
      end
   end

   assign fmt_cur = start ? fmt_new : fmt_q;
   assign active  = (st_q != SQ_IDLE);

endmodule

// File: rtl/lxe_line.sv
module lxe_line
   import lxe_pkg::*;
#(
   parameter bit IDLE_LVL  = 1'b1,
   parameter bit NRZI_INIT = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     mid_stb,
   input  logic     emit,
   input  logic     emit_bit,
   input  logic     start,
   input  logic     to_idle,
   input  lxe_fmt_e fmt,
   output logic     line,
   output logic     armed
);

   logic nrzi_q, half2_q;
   logic nrzi_base, nrzi_next;

   assign nrzi_base = start ? NRZI_INIT : nrzi_q;
   assign nrzi_next = emit_bit ? nrzi_base : ~nrzi_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line    <= IDLE_LVL;
         nrzi_q  <= NRZI_INIT;
         half2_q <= IDLE_LVL;
         armed   <= 1'b0;
      end else if (emit) begin
         unique case (fmt)
            FMT_NRZI: begin
               line   <= nrzi_next;
               nrzi_q <= nrzi_next;
               armed  <= 1'b0;
            end
            FMT_MANCH: begin
               line    <= emit_bit;
               half2_q <= ~emit_bit;
               armed   <= 1'b1;
            end
            default: begin
               line  <= emit_bit;
               armed <= 1'b0;
            end
         endcase
      end else if (to_idle) begin
         line  <= IDLE_LVL;
         armed <= 1'b0;
      end else if (mid_stb && armed) begin
         line  <= half2_q;
         armed <= 1'b0;
      end
   end

endmodule

// File: rtl/mfmt_line_enc.sv
module mfmt_line_enc
   import lxe_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PRE_W     = 4,
   parameter bit LSB_FIRST = 1'b1,
   parameter bit IDLE_LVL  = 1'b1,
   parameter bit NRZI_INIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cell_stb,
   input  logic              mid_stb,
   input  logic [1:0]        fmt_sel,
   input  logic [PRE_W-1:0]  pre_len,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              line_out
);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("mfmt_line_enc: DATA_W must be at least 2");
      end
      if (PRE_W < 1 || PRE_W > 8) begin : g_bad_pre_w
         $error("mfmt_line_enc: PRE_W must be within 1..8");
      end
   endgenerate

   logic              hold_full, take;
   logic [DATA_W-1:0] hold_data;
   logic              emit, emit_bit, start, to_idle;
   lxe_fmt_e          fmt_cur;
   logic              frm_active;
   logic              man_armed;

   lxe_hold #(.DATA_W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (tx_valid),
      .in_ready (tx_ready),
      .in_data  (tx_data),
      .take     (take),
      .full     (hold_full),
      .data     (hold_data)
   );

   lxe_seq #(
      .DATA_W    (DATA_W),
      .PRE_W     (PRE_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cell_stb   (cell_stb),
      .fmt_in     (fmt_sel),
      .pre_len_in (pre_len),
      .hold_full  (hold_full),
      .hold_data  (hold_data),
      .take       (take),
      .emit       (emit),
      .emit_bit   (emit_bit),
      .start      (start),
      .to_idle    (to_idle),
      .fmt_cur    (fmt_cur),
      .active     (frm_active)
   );

   lxe_line #(
      .IDLE_LVL  (IDLE_LVL),
      .NRZI_INIT (NRZI_INIT)
   ) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .mid_stb  (mid_stb),
      .emit     (emit),
      .emit_bit (emit_bit),
      .start    (start),
      .to_idle  (to_idle),
      .fmt      (fmt_cur),
      .line     (line_out),
      .armed    (man_armed)
   );

endmodule

// File: rtl/mfmt_line_enc_chk.sv
module mfmt_line_enc_chk #(
   parameter bit IDLE_LVL = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic cell_stb,
   input logic mid_stb,
   input logic tx_valid,
   input logic tx_ready,
   input logic line_out,
   input logic frm_active,
   input logic man_armed
);

   AST_IDLE_MARKING: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_active |-> line_out == IDLE_LVL); // R1

   AST_HOLD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready); // R2

   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_ready && !cell_stb) |=> !tx_ready); // R2

   AST_MID_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_stb && man_armed && !cell_stb) |=> line_out != $past(line_out)); // R5

   AST_EDGE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (line_out != $past(line_out)) |-> ($past(cell_stb) || $past(mid_stb))); // R10

endmodule

bind mfmt_line_enc mfmt_line_enc_chk #(.IDLE_LVL(IDLE_LVL)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cell_stb   (cell_stb),
   .mid_stb    (mid_stb),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .line_out   (line_out),
   .frm_active (frm_active),
   .man_armed  (man_armed)
);

// File: tb/mfmt_line_enc_test.sv
module mfmt_line_enc_test;

   localparam int H = 4; // clock cycles per half bit cell

   typedef struct packed {
      logic [1:0] fmt;
      logic [3:0] pre;
      logic [1:0] nb;
      logic [7:0] b0;
      logic [7:0] b1;
      logic [7:0] b2;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{fmt:2'd0, pre:4'd0,  nb:2'd1, b0:8'hA5, b1:8'h00, b2:8'h00},
      '{fmt:2'd1, pre:4'd0,  nb:2'd2, b0:8'h00, b1:8'hFE, b2:8'h00},
      '{fmt:2'd1, pre:4'd4,  nb:2'd2, b0:8'h3C, b1:8'h81, b2:8'h00},
      '{fmt:2'd2, pre:4'd0,  nb:2'd1, b0:8'h26, b1:8'h00, b2:8'h00},
      '{fmt:2'd2, pre:4'd5,  nb:2'd1, b0:8'hC3, b1:8'h00, b2:8'h00},
      '{fmt:2'd0, pre:4'd3,  nb:2'd1, b0:8'hFF, b1:8'h00, b2:8'h00},
      '{fmt:2'd2, pre:4'd15, nb:2'd2, b0:8'h00, b1:8'hFF, b2:8'h00},
      '{fmt:2'd1, pre:4'd15, nb:2'd3, b0:8'h55, b1:8'hAA, b2:8'h0F},
      '{fmt:2'd3, pre:4'd2,  nb:2'd1, b0:8'h96, b1:8'h00, b2:8'h00},
      '{fmt:2'd0, pre:4'd1,  nb:2'd3, b0:8'h01, b1:8'h80, b2:8'h7E}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cell_stb = 1'b0;
   logic       mid_stb = 1'b0;
   logic [1:0] fmt_sel = 2'b00;
   logic [3:0] pre_len = 4'd0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic       line_out;

   int nvec = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mfmt_line_enc uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cell_stb (cell_stb),
      .mid_stb  (mid_stb),
      .fmt_sel  (fmt_sel),
      .pre_len  (pre_len),
      .tx_data  (tx_data),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .line_out (line_out)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // one idle half cell with an optional strobe at its start; checks line after it
   task automatic half_cell(input bit is_cell, input logic exp, input string req);
      if (is_cell) cell_stb = 1'b1; else mid_stb = 1'b1;
      @(negedge clk);
      cell_stb = 1'b0;
      mid_stb  = 1'b0;
      chk(req, line_out, exp);
      repeat (H - 1) @(negedge clk);
   endtask

   task automatic run_frame(input vec_t v);
      logic bits [64];
      logic e1 [64];
      logic e2 [64];
      logic [7:0] bytes [3];
      string tags [64];
      int n;
      int nxt;
      logic lvl;
      bit man;
      bytes[0] = v.b0;
      bytes[1] = v.b1;
      bytes[2] = v.b2;
      man = (v.fmt == 2'd2);
      n = 0;
      for (int i = 0; i < int'(v.pre); i++) begin
         bits[n] = man ? ((i % 2) == 0) : 1'b0; // R7 pattern
         tags[n] = "R7";
         n++;
      end
      for (int j = 0; j < int'(v.nb); j++) begin
         for (int i = 0; i < 8; i++) begin
            bits[n] = bytes[j][i]; // R6 LSB first
            if (v.fmt == 2'd3)      tags[n] = "R8";
            else if (j > 0)         tags[n] = "R6";
            else if (v.fmt == 2'd0) tags[n] = "R3";
            else if (v.fmt == 2'd1) tags[n] = "R4";
            else                    tags[n] = "R5";
            n++;
         end
      end
      lvl = 1'b1;
      for (int k = 0; k < n; k++) begin
         if (v.fmt == 2'd1) begin
            if (bits[k] == 1'b0) lvl = ~lvl;
            e1[k] = lvl;
            e2[k] = lvl;
         end else if (man) begin
            e1[k] = bits[k];
            e2[k] = ~bits[k];
         end else begin
            e1[k] = bits[k];
            e2[k] = bits[k];
         end
      end
      fmt_sel  = v.fmt;
      pre_len  = v.pre;
      tx_data  = v.b0;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      chk("R2 ready low while byte held", tx_ready, 1'b0);
      nxt = 1;
      for (int k = 0; k <= n; k++) begin
         cell_stb = 1'b1;
         if (nxt < int'(v.nb) && tx_ready) begin
            tx_valid = 1'b1; // refill in the same cycle as a cell strobe
            tx_data  = bytes[nxt];
            nxt++;
         end
         @(negedge clk);
         cell_stb = 1'b0;
         tx_valid = 1'b0;
         if (k == 1) begin
            fmt_sel = v.fmt + 2'd1; // R8: ignored until the next frame
            pre_len = ~v.pre;
         end
         if (k < n) chk(tags[k], line_out, e1[k]);
         else       chk("R9 idle after frame", line_out, 1'b1);
         repeat (H - 1) @(negedge clk);
         mid_stb = 1'b1;
         @(negedge clk);
         mid_stb = 1'b0;
         if (k < n) chk(tags[k], line_out, e2[k]);
         else       chk("R9 idle after frame", line_out, 1'b1);
         repeat (H - 1) @(negedge clk);
      end
      chk("R2 ready back after frame", tx_ready, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 line during reset", line_out, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 line after reset", line_out, 1'b1);
      chk("R1 ready after reset", tx_ready, 1'b1);

      for (int i = 0; i < NV; i++) run_frame(VECS[i]);

      // R1 / R9: strobes with nothing pending leave the line marking
      half_cell(1'b1, 1'b1, "R1 idle cell strobe");
      half_cell(1'b0, 1'b1, "R1 idle mid strobe");
      chk("R1 ready idle", tx_ready, 1'b1);

      // R2: a byte stays held across mid strobes until a cell strobe
      fmt_sel  = 2'd2;
      pre_len  = 4'd0;
      tx_data  = 8'h01;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      half_cell(1'b0, 1'b1, "R2 mid strobe does not start frame");
      chk("R2 still held", tx_ready, 1'b0);
      half_cell(1'b1, 1'b1, "R5 first half of 1");
      chk("R2 freed by cell strobe", tx_ready, 1'b1);
      half_cell(1'b0, 1'b0, "R5 second half of 1");
      half_cell(1'b1, 1'b0, "R5 first half of 0");

      // R1: reset in mid frame
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 line on mid-frame reset", line_out, 1'b1);
      chk("R1 ready on mid-frame reset", tx_ready, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      half_cell(1'b0, 1'b1, "R1 mid strobe after reset");
      half_cell(1'b1, 1'b1, "R1 cell strobe after reset");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nvec++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

endmodule